// File: doc/BRIEF.md
# Highway and Farm-Road Crossing Lamp Controller

This block runs the lamps at a crossing where a busy highway meets a quiet farm road. It has four phases. In the first the highway is green and the farm road red. In the second the highway is yellow and the farm road red. In the third the farm road is green and the highway red. In the fourth the farm road is yellow and the highway red. The highway keeps green for as long as no vehicle waits on the farm road. It only gives way once a vehicle is detected and it has held green for at least one long interval.

The farm road keeps green while vehicles remain, and never for longer than one long interval. Each yellow lasts one short interval. The block contains its own interval timer, which has a tick prescaler and parameterised short and long counts. The state machine restarts that timer with a one-cycle pulse whenever the phase is about to change. The restart pulse is decided from the current phase and the present inputs. The lamps depend on the phase register alone.

Top module: `xlc_crossing_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows highway green and farm red, and `timer_restart` is low while `rst` is high.
- R2: Each lamp bus is one-hot with bit 0 green, bit 1 yellow and bit 2 red. At least one road is red at all times, and both roads are never green or yellow together.
- R3: With `car_wait` low, the highway green phase is never left.
- R4: Highway green lasts at least LONG_TICKS*PRESCALE+1 cycles, counted from its first cycle, before highway yellow.
- R5: Each yellow phase lasts exactly SHORT_TICKS*PRESCALE+1 cycles. Highway yellow is followed by farm green, and farm yellow is followed by highway green.
- R6: Farm green turns to farm yellow at the edge after a cycle in which `car_wait` is low. Farm green never lasts more than LONG_TICKS*PRESCALE+1 cycles.
- R7: `timer_restart` is high for exactly those cycles whose following rising edge changes the phase. It depends on the current phase and `car_wait` within the same cycle.
- R8: When `car_wait` stays high for the whole of a highway green phase, that phase lasts exactly LONG_TICKS*PRESCALE+1 cycles. This holds because the timer restarts at every phase entry.
- R9: When `car_wait` stays high for the whole of a farm green phase, that phase lasts exactly LONG_TICKS*PRESCALE+1 cycles. The timer advances only on prescaler ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| car_wait | input | 1 | High while a vehicle is detected on the farm road |
| hwy_lamp | output | 3 | Highway lamps, one-hot {red, yellow, green} |
| farm_lamp | output | 3 | Farm-road lamps, one-hot {red, yellow, green} |
| timer_restart | output | 1 | One-cycle timer restart, issued on every phase change |

## Verification
The hardest corner to reach from the ports is a green phase ended by the long interval with the vehicle sensor held high the whole time. Random stimulus seldom keeps `car_wait` high long enough, so the bench holds it high on purpose across whole cycles of phases. It also drops it at chosen points inside farm green, and it puts a reset in the middle of farm green. Random bursts of sensor activity of varied length then cover sensor changes during the yellow phases. A bench model of elapsed cycles per phase predicts every lamp state and every restart pulse.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_t;

  localparam int LAMP_G = 0;
  localparam int LAMP_Y = 1;
  localparam int LAMP_R = 2;

  // Lamp word of one road for a given phase
  function automatic logic [2:0] road_lamp(phase_t p, logic is_farm);
    logic go, warn;
    logic [2:0] w;
    go   = is_farm ? (p == PH_FARM_GO)   : (p == PH_HWY_GO);
    warn = is_farm ? (p == PH_FARM_WARN) : (p == PH_HWY_WARN);
    w = 3'b000;
    if (go)        w[LAMP_G] = 1'b1;
    else if (warn) w[LAMP_Y] = 1'b1;
    else           w[LAMP_R] = 1'b1;
    return w;
  endfunction

  // Phase sequencing rule
  function automatic phase_t phase_after(phase_t p, logic car,
                                         logic short_done, logic long_done);
    phase_t n;
    n = p;
    case (p)
      PH_HWY_GO:    if (car && long_done)  n = PH_HWY_WARN;
      PH_HWY_WARN:  if (short_done)        n = PH_FARM_GO;
      PH_FARM_GO:   if (!car || long_done) n = PH_FARM_WARN;
      PH_FARM_WARN: if (short_done)        n = PH_HWY_GO;
      default:                             n = PH_HWY_GO;
    endcase
    return n;
  endfunction

  // Cycles a phase lasts when it is timed out after a given tick count
  function automatic int unsigned dwell_cycles(int unsigned ticks,
                                               int unsigned prescale);
    return ticks * prescale + 1;
  endfunction

endpackage

// File: rtl/xlc_interval_timer.sv
module xlc_interval_timer #(
  parameter int SHORT_TICKS = 5,
  parameter int LONG_TICKS  = 30,
  parameter int PRESCALE    = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = $clog2(LONG_TICKS + 1);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] CNT_LONG  = CW'(LONG_TICKS);
  localparam logic [CW-1:0] CNT_SHORT = CW'(SHORT_TICKS);

  logic          tick;
  logic [CW-1:0] cnt_q;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || restart)      pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                     pre_q <= pre_q + PW'(1);
      end
      assign tick = (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || restart)                 cnt_q <= '0;
    else if (tick && cnt_q != CNT_LONG) cnt_q <= cnt_q + CW'(1);
  end

  assign short_done = (cnt_q >= CNT_SHORT);
  assign long_done  = (cnt_q >= CNT_LONG);

  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0)); // R8
  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!restart && !tick) |=> $stable(cnt_q)); // R9
  AST_TIMER_SAT: assert property (@(posedge clk) disable iff (rst)
    (!restart && long_done) |=> long_done); // R9
  AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (rst)
    long_done |-> short_done); // R5
endmodule

// File: rtl/xlc_phase_fsm.sv
module xlc_phase_fsm
  import xlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   car,
  input  logic   short_done,
  input  logic   long_done,
  output phase_t phase,
  output logic   restart
);
  phase_t phase_q, phase_d;

  always_comb phase_d = phase_after(phase_q, car, short_done, long_done);

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_HWY_GO;
    else     phase_q <= phase_d;
  end

  assign restart = !rst && (phase_d != phase_q);
  assign phase   = phase_q;

  AST_HWY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HWY_GO && !car) |=> (phase_q == PH_HWY_GO)); // R3
  AST_HWY_MIN: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HWY_GO && !long_done) |=> (phase_q == PH_HWY_GO)); // R4
  AST_WARN_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_HWY_WARN || phase_q == PH_FARM_WARN) && !short_done)
      |=> $stable(phase_q)); // R5
  AST_FARM_DROP: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_FARM_GO && !car) |=> (phase_q == PH_FARM_WARN)); // R6
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
    restart |=> (phase_q != $past(phase_q))); // R7
  AST_NO_SILENT_STEP: assert property (@(posedge clk) disable iff (rst)
    !restart |=> $stable(phase_q)); // R7
endmodule

// File: rtl/xlc_lamp_drive.sv
module xlc_lamp_drive
  import xlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_t     phase,
  output logic [2:0] hwy_lamp,
  output logic [2:0] farm_lamp
);
  always_comb begin
    hwy_lamp  = road_lamp(phase, 1'b0);
    farm_lamp = road_lamp(phase, 1'b1);
  end

  AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    ($countones(hwy_lamp) == 1) && ($countones(farm_lamp) == 1)); // R2
  AST_ONE_ROAD_RED: assert property (@(posedge clk) disable iff (rst)
    hwy_lamp[LAMP_R] || farm_lamp[LAMP_R]); // R2
  AST_NO_DOUBLE_GO: assert property (@(posedge clk) disable iff (rst)
    !(hwy_lamp[LAMP_G] && farm_lamp[LAMP_G])); // R2
endmodule

// File: rtl/xlc_crossing_ctrl.sv
module xlc_crossing_ctrl
  import xlc_pkg::*;
#(
  parameter int SHORT_TICKS = 5,
  parameter int LONG_TICKS  = 30,
  parameter int PRESCALE    = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_wait,
  output logic [2:0] hwy_lamp,
  output logic [2:0] farm_lamp,
  output logic       timer_restart
);
  logic   short_done, long_done, restart;
  phase_t phase;

  xlc_interval_timer #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS),
    .PRESCALE   (PRESCALE)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .short_done(short_done),
    .long_done (long_done)
  );

  xlc_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .car       (car_wait),
    .short_done(short_done),
    .long_done (long_done),
    .phase     (phase),
    .restart   (restart)
  );

  xlc_lamp_drive u_lamps (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .hwy_lamp (hwy_lamp),
    .farm_lamp(farm_lamp)
  );

  assign timer_restart = restart;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> !timer_restart); // R1
endmodule

// File: tb/xlc_crossing_ctrl_test.sv
module xlc_crossing_ctrl_test;
  localparam int S = 3;
  localparam int L = 6;
  localparam int P = 2;
  localparam int YEL_CYC  = S * P + 1;
  localparam int LONG_CYC = L * P + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       car_wait = 1'b0;
  logic [2:0] hwy_lamp, farm_lamp;
  logic       timer_restart;

  int checks = 0;
  int errors = 0;
  int mph = 0, d = 0;
  int prev_ph = 0, run = 0;
  bit run_valid = 0, run_car = 1;
  int unsigned seed_sink;

  xlc_crossing_ctrl #(.SHORT_TICKS(S), .LONG_TICKS(L), .PRESCALE(P)) uut (
    .clk(clk), .rst(rst), .car_wait(car_wait),
    .hwy_lamp(hwy_lamp), .farm_lamp(farm_lamp), .timer_restart(timer_restart)
  );

  always #10 clk = ~clk;

  function automatic int decode(logic [2:0] h, logic [2:0] f);
    if (h == 3'b001 && f == 3'b100) return 0;
    if (h == 3'b010 && f == 3'b100) return 1;
    if (h == 3'b100 && f == 3'b001) return 2;
    if (h == 3'b100 && f == 3'b010) return 3;
    return -1;
  endfunction

  // Model: elapsed cycles d since phase entry, ticks every P cycles
  function automatic int model_next(int ph, bit c, int el);
    bit sdone = (el >= S * P);
    bit ldone = (el >= L * P);
    case (ph)
      0: return (c && ldone) ? 1 : 0;
      1: return sdone ? 2 : 1;
      2: return (!c || ldone) ? 3 : 2;
      default: return sdone ? 0 : 3;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    car_wait = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    chk(decode(hwy_lamp, farm_lamp) == 0, "R1 reset phase",
        decode(hwy_lamp, farm_lamp), 0);
    chk(timer_restart == 1'b0, "R1 restart quiet in reset", timer_restart, 0);
    rst = 1'b0;
    mph = 0; d = 0; prev_ph = 0; run = 0; run_valid = 0; run_car = 1;
  endtask

  task automatic step(bit c);
    int ph, nx;
    car_wait = c;
    #1;
    ph = decode(hwy_lamp, farm_lamp);
    chk(ph != -1, "R2 lamp encoding", {29'd0, hwy_lamp}, {29'd0, farm_lamp});
    chk(ph == mph, "R5 phase sequence", ph, mph);
    nx = model_next(mph, c, d);
    chk(timer_restart == (nx != mph), "R7 restart pulse",
        timer_restart, (nx != mph) ? 1 : 0);
    if (ph != prev_ph) begin
      if (run_valid) begin
        case (prev_ph)
          0: begin
            chk(run >= LONG_CYC, "R4 highway min green", run, LONG_CYC);
            if (run_car) chk(run == LONG_CYC, "R8 highway green exact", run, LONG_CYC);
          end
          2: begin
            chk(run <= LONG_CYC, "R6 farm green max", run, LONG_CYC);
            if (run_car) chk(run == LONG_CYC, "R9 farm green exact", run, LONG_CYC);
          end
          default: chk(run == YEL_CYC, "R5 yellow dwell", run, YEL_CYC);
        endcase
      end
      prev_ph = ph; run = 0; run_valid = 1; run_car = 1;
    end
    run++;
    run_car = run_car && c;
    @(posedge clk);
    @(negedge clk);
    if (nx == mph) d++;
    else begin mph = nx; d = 0; end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seed_sink = $urandom(32'd2024);
    @(negedge clk);
    do_reset();

    // R3: no farm car, highway holds
    for (int i = 0; i < 40; i++) begin
      step(1'b0);
      chk(decode(hwy_lamp, farm_lamp) == 0, "R3 highway hold",
          decode(hwy_lamp, farm_lamp), 0);
    end

    // R8/R9: car held across several full cycles
    for (int i = 0; i < 120; i++) step(1'b1);

    // R6: car leaves early in farm green
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 60 && mph != 2; i++) step(1'b1);
      for (int i = 0; i < k; i++) step(1'b1);
      chk(mph == 2, "R6 reached farm green", mph, 2);
      step(1'b0);
      chk(mph == 3, "R6 early end", mph, 3);
      for (int i = 0; i < 12; i++) step(1'b0);
    end

    // R1: reset in the middle of farm green
    for (int i = 0; i < 60 && mph != 2; i++) step(1'b1);
    step(1'b1);
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b1);

    // Random bursts of sensor activity
    for (int b = 0; b < 400; b++) begin
      bit c;
      int len;
      c = ($urandom % 3) != 0;
      len = 1 + ($urandom % 16);
      for (int i = 0; i < len; i++) step(c);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule